// File: doc/BRIEF.md
# Three-Step Block Motion Search

This block finds the motion vector of one image block with a coarse-to-fine search over three step sizes. A start pulse launches a search centred on zero displacement. The block sends candidate displacements one at a time to an external matching-cost unit. That unit returns the sum of absolute differences (SAD) between the current block and the previous reconstructed frame shifted by the candidate. The block keeps the cheapest candidate seen so far.

The first step scores the origin and its eight neighbours at a distance of four. The next two steps move the centre to the best point found so far and score the eight neighbours again at half the previous distance. The centre's score is carried over, so it is not scored again. Any candidate beyond the displacement limit is skipped without being scored. When the search ends, the block raises done for one cycle. It then holds four results: the winning displacement, its SAD, and the SAD at zero displacement, which a later intra/inter mode decision can use.

Top module: `tss_search`

## Requirements
- R1: After a start pulse in idle, the first candidate issued is (0,0), and `zero_sad` reports the SAD returned for it.
- R2: Within a step, after the centre (first step only), the eight neighbours are issued row by row from the top row (dy = centre − step) to the bottom row, and left to right within a row (dx increasing). Positive dx is to the right and positive dy is downward. Both are two's complement.
- R3: Each step after the first is centred on the best displacement held at the end of the previous step, and its centre is not issued again.
- R4: The step distances are FIRST_STEP, then halved after each step down to 1 (4, 2, 1 by default), and the search ends after the distance-1 step.
- R5: A candidate with |dx| or |dy| greater than MAX_DISP is skipped and never issued, and the reported displacement stays within ±MAX_DISP.
- R6: A search issues at most 1 + 8 × (number of steps) candidates (25 by default).
- R7: A returned SAD replaces the held best only when it is strictly smaller, so on equal SAD the earlier-issued candidate wins.
- R8: `done` is high for exactly one cycle per search, and `best_dx`, `best_dy`, `best_sad` and `zero_sad` keep their values after it until the next accepted start.
- R9: `cand_valid` is a one-cycle pulse, and no further candidate is issued until `sad_valid` returns, whatever the return latency.
- R10: A start pulse during a search is ignored, and the running search completes unchanged.
- R11: Reset (synchronous, active low) leaves the block idle with `cand_valid` and `done` low and all result outputs zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a search (only honoured when idle) |
| cand_valid | output | 1 | One-cycle request to score a candidate |
| cand_dx | output | DISP_W | Candidate horizontal displacement, signed |
| cand_dy | output | DISP_W | Candidate vertical displacement, signed |
| sad_valid | input | 1 | SAD for the outstanding candidate is on `sad_in` |
| sad_in | input | SAD_W | Returned SAD |
| done | output | 1 | One-cycle end-of-search pulse |
| best_dx | output | DISP_W | Winning horizontal displacement |
| best_dy | output | DISP_W | Winning vertical displacement |
| best_sad | output | SAD_W | SAD of the winning displacement |
| zero_sad | output | SAD_W | SAD at zero displacement |

## Verification
A wrong neighbour index, centre or step register shows at the ports in the same cycle, as a candidate that departs from the expected raster sequence. A wrong comparison in the best-keeper shows up one step later as a wrongly placed centre, and the final displacement or SAD then differs at `done`. A stale sequencing state appears as an extra or missing candidate, so the evaluation count and the out-of-range screening are checked on every run, both with the default limit and with a tighter one.

// File: rtl/tss_pkg.sv
// Shared types for the three-step motion search.
package tss_pkg;
    // Controller states of the search sequencer.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_ADV,
        ST_DONE
    } tss_state_e;

    // Per-axis neighbour offset direction, scaled by the current step.
    typedef enum logic [1:0] {
        OFF_NEG,
        OFF_ZERO,
        OFF_POS
    } tss_off_e;
endpackage

// File: rtl/tss_cand_gen.sv
// Candidate generator: maps a neighbour index (0 = centre, 1..8 = raster
// order around it) plus centre and step to a displacement, and flags whether
// that displacement lies within +/-MAX_DISP. Purely combinational.
// Assumes the centre itself is always within range.
module tss_cand_gen
    import tss_pkg::*;
#(
    parameter int MAX_DISP = 7,
    parameter int DISP_W   = 4,
    parameter int STEP_W   = 3
) (
    input  logic signed [DISP_W-1:0] centre_x,
    input  logic signed [DISP_W-1:0] centre_y,
    input  logic        [STEP_W-1:0] step,
    input  logic        [3:0]        idx,
    output logic signed [DISP_W-1:0] cand_x,
    output logic signed [DISP_W-1:0] cand_y,
    output logic                     in_range
);
    localparam int EXT_W = DISP_W + STEP_W + 1;
    localparam logic signed [EXT_W-1:0] LIM = EXT_W'(MAX_DISP);

    tss_off_e col, row;
    logic signed [EXT_W-1:0] cx_e, cy_e, step_e, sx, sy;

    // Neighbour index to row/column direction (raster order, centre skipped).
    always_comb begin
        unique case (idx)
            4'd0:    begin col = OFF_ZERO; row = OFF_ZERO; end
            4'd1:    begin col = OFF_NEG;  row = OFF_NEG;  end
            4'd2:    begin col = OFF_ZERO; row = OFF_NEG;  end
            4'd3:    begin col = OFF_POS;  row = OFF_NEG;  end
            4'd4:    begin col = OFF_NEG;  row = OFF_ZERO; end
            4'd5:    begin col = OFF_POS;  row = OFF_ZERO; end
            4'd6:    begin col = OFF_NEG;  row = OFF_POS;  end
            4'd7:    begin col = OFF_ZERO; row = OFF_POS;  end
            default: begin col = OFF_POS;  row = OFF_POS;  end
        endcase
    end

    // Widened displacement arithmetic so out-of-range sums do not wrap.
    always_comb begin
        cx_e   = EXT_W'(centre_x);
        cy_e   = EXT_W'(centre_y);
        step_e = EXT_W'(step);
        sx = (col == OFF_NEG) ? cx_e - step_e : (col == OFF_ZERO) ? cx_e : cx_e + step_e;
        sy = (row == OFF_NEG) ? cy_e - step_e : (row == OFF_ZERO) ? cy_e : cy_e + step_e;
    end

    assign in_range = (sx <= LIM) && (sx >= -LIM) && (sy <= LIM) && (sy >= -LIM);
    assign cand_x   = sx[DISP_W-1:0];
    assign cand_y   = sy[DISP_W-1:0];
endmodule

// File: rtl/tss_best_keeper.sv
// Best-candidate register: captures the first returned score unconditionally
// (the origin) and afterwards replaces the held best only on a strictly
// smaller score. Also latches the origin score as the zero-motion cost.
module tss_best_keeper #(
    parameter int DISP_W = 4,
    parameter int SAD_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     take,
    input  logic                     first,
    input  logic signed [DISP_W-1:0] cand_x,
    input  logic signed [DISP_W-1:0] cand_y,
    input  logic        [SAD_W-1:0]  sad_in,
    output logic signed [DISP_W-1:0] best_x,
    output logic signed [DISP_W-1:0] best_y,
    output logic        [SAD_W-1:0]  best_sad,
    output logic        [SAD_W-1:0]  zero_sad
);
    // Keep the lowest score; ties keep the earlier candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_x   <= '0;
            best_y   <= '0;
            best_sad <= '0;
        end else if (take && (first || sad_in < best_sad)) begin
            best_x   <= cand_x;
            best_y   <= cand_y;
            best_sad <= sad_in;
        end
    end

    // Record the zero-displacement score for the mode decision.
    always_ff @(posedge clk) begin
        if (!rst_n)
            zero_sad <= '0;
        else if (take && first)
            zero_sad <= sad_in;
    end
endmodule

// File: rtl/tss_search.sv
// Three-step motion search controller. Issues one candidate at a time to an
// external SAD unit and waits for its result before the next one. The step
// starts at FIRST_STEP (a power of two) and halves down to 1, re-centring on
// the best point between steps. Candidates outside +/-MAX_DISP are skipped.
module tss_search
    import tss_pkg::*;
#(
    parameter int MAX_DISP   = 7,
    parameter int FIRST_STEP = 4,
    parameter int SAD_W      = 16,
    localparam int DISP_W    = $clog2(MAX_DISP + 1) + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    output logic                     cand_valid,
    output logic signed [DISP_W-1:0] cand_dx,
    output logic signed [DISP_W-1:0] cand_dy,
    input  logic                     sad_valid,
    input  logic        [SAD_W-1:0]  sad_in,
    output logic                     done,
    output logic signed [DISP_W-1:0] best_dx,
    output logic signed [DISP_W-1:0] best_dy,
    output logic        [SAD_W-1:0]  best_sad,
    output logic        [SAD_W-1:0]  zero_sad
);
    localparam int STEP_W = $clog2(FIRST_STEP + 1);
    localparam logic [3:0] LAST_IDX = 4'd8;

    tss_state_e              state;
    logic signed [DISP_W-1:0] centre_x, centre_y;
    logic        [STEP_W-1:0] step;
    logic        [3:0]        idx;
    logic                     in_range;
    logic                     take;

    tss_cand_gen #(
        .MAX_DISP(MAX_DISP),
        .DISP_W  (DISP_W),
        .STEP_W  (STEP_W)
    ) u_cand_gen (
        .centre_x(centre_x),
        .centre_y(centre_y),
        .step    (step),
        .idx     (idx),
        .cand_x  (cand_dx),
        .cand_y  (cand_dy),
        .in_range(in_range)
    );

    assign take = (state == ST_WAIT) && sad_valid;

    tss_best_keeper #(
        .DISP_W(DISP_W),
        .SAD_W (SAD_W)
    ) u_best (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .first   (idx == 4'd0),
        .cand_x  (cand_dx),
        .cand_y  (cand_dy),
        .sad_in  (sad_in),
        .best_x  (best_dx),
        .best_y  (best_dy),
        .best_sad(best_sad),
        .zero_sad(zero_sad)
    );

    // Sequence candidates, steps and re-centring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            centre_x <= '0;
            centre_y <= '0;
            step     <= STEP_W'(FIRST_STEP);
            idx      <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    centre_x <= '0;
                    centre_y <= '0;
                    step     <= STEP_W'(FIRST_STEP);
                    idx      <= '0;
                    state    <= ST_ISSUE;
                end
                ST_ISSUE: state <= in_range ? ST_WAIT : ST_ADV;
                ST_WAIT:  if (sad_valid) state <= ST_ADV;
                ST_ADV: begin
                    if (idx != LAST_IDX) begin
                        idx   <= idx + 4'd1;
                        state <= ST_ISSUE;
                    end else if (step == STEP_W'(1)) begin
                        state <= ST_DONE;
                    end else begin
                        centre_x <= best_dx;
                        centre_y <= best_dy;
                        step     <= step >> 1;
                        idx      <= 4'd1;
                        state    <= ST_ISSUE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cand_valid = (state == ST_ISSUE) && in_range;
    assign done       = (state == ST_DONE);
endmodule

// File: rtl/tss_search_chk.sv
// Port-level checker for tss_search, bound to every instance.
module tss_search_chk #(
    parameter int MAX_DISP   = 7,
    parameter int FIRST_STEP = 4,
    parameter int SAD_W      = 16,
    localparam int DISP_W    = $clog2(MAX_DISP + 1) + 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cand_valid,
    input logic signed [DISP_W-1:0] cand_dx,
    input logic signed [DISP_W-1:0] cand_dy,
    input logic                     done,
    input logic signed [DISP_W-1:0] best_dx,
    input logic signed [DISP_W-1:0] best_dy,
    input logic        [SAD_W-1:0]  best_sad,
    input logic        [SAD_W-1:0]  zero_sad
);
    localparam int NUM_STEPS = $clog2(FIRST_STEP) + 1;
    localparam int MAX_EVALS = 1 + 8 * NUM_STEPS;
    localparam int CNT_W     = $clog2(MAX_EVALS + 1) + 1;
    localparam logic signed [DISP_W-1:0] LIM = DISP_W'(MAX_DISP);

    logic [CNT_W-1:0] eval_cnt;

    // Count candidates issued since the last done.
    always_ff @(posedge clk) begin
        if (!rst_n)          eval_cnt <= '0;
        else if (done)       eval_cnt <= '0;
        else if (cand_valid) eval_cnt <= eval_cnt + 1'b1;
    end

    AST_CAND_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (cand_dx <= LIM && cand_dx >= -LIM && cand_dy <= LIM && cand_dy >= -LIM)); // R5
    AST_EVAL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |-> (eval_cnt < CNT_W'(MAX_EVALS))); // R6
    AST_CAND_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cand_valid |=> !cand_valid); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_BEST_NOT_WORSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (best_sad <= zero_sad)); // R7
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(done) |-> ($stable(best_dx) && $stable(best_dy) && $stable(best_sad))); // R8
    AST_DONE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (best_dx <= LIM && best_dx >= -LIM && best_dy <= LIM && best_dy >= -LIM)); // R5
endmodule

bind tss_search tss_search_chk #(
    .MAX_DISP  (MAX_DISP),
    .FIRST_STEP(FIRST_STEP),
    .SAD_W     (SAD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand_valid(cand_valid),
    .cand_dx   (cand_dx),
    .cand_dy   (cand_dy),
    .done      (done),
    .best_dx   (best_dx),
    .best_dy   (best_dy),
    .best_sad  (best_sad),
    .zero_sad  (zero_sad)
);

// File: tb/tss_search_bench.sv
// Bench: two instances (default limit and a tighter one) scored by a
// synthetic cost surface, compared against a reference search model.
module tss_search_bench;
    localparam int SAD_W  = 16;
    localparam int FS     = 4;
    localparam int WIDE   = 7;
    localparam int NARROW = 5;
    localparam int WD_W   = $clog2(WIDE + 1) + 1;
    localparam int ND_W   = $clog2(NARROW + 1) + 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n = 1'b0;
    logic start = 1'b0;

    logic                    a_cv, a_done, a_sv = 1'b0;
    logic signed [WD_W-1:0]  a_dx, a_dy, a_bdx, a_bdy;
    logic [SAD_W-1:0]        a_sd = '0, a_bs, a_zs;
    logic                    b_cv, b_done, b_sv = 1'b0;
    logic signed [ND_W-1:0]  b_dx, b_dy, b_bdx, b_bdy;
    logic [SAD_W-1:0]        b_sd = '0, b_bs, b_zs;

    tss_search #(.MAX_DISP(WIDE), .FIRST_STEP(FS), .SAD_W(SAD_W)) u_tss_search (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cand_valid(a_cv), .cand_dx(a_dx), .cand_dy(a_dy),
        .sad_valid(a_sv), .sad_in(a_sd), .done(a_done),
        .best_dx(a_bdx), .best_dy(a_bdy), .best_sad(a_bs), .zero_sad(a_zs));

    tss_search #(.MAX_DISP(NARROW), .FIRST_STEP(FS), .SAD_W(SAD_W)) u_tss_search_narrow (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cand_valid(b_cv), .cand_dx(b_dx), .cand_dy(b_dy),
        .sad_valid(b_sv), .sad_in(b_sd), .done(b_done),
        .best_dx(b_bdx), .best_dy(b_bdy), .best_sad(b_bs), .zero_sad(b_zs));

    int checks = 0, errors = 0;
    int s_tx, s_ty, s_wa, s_wb, s_base, s_namp, s_nseed;
    int a_ev, b_ev, a_dcnt, b_dcnt, a_viol, b_viol, b_oor;
    bit a_fin, b_fin;
    int a_sx[32], a_sy[32], r_sx[32], r_sy[32];

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Synthetic cost surface: a valley at (s_tx, s_ty) plus hashed noise.
    function automatic int sad_of(input int x, input int y);
        return s_base + s_wa * iabs(x - s_tx) + s_wb * iabs(y - s_ty)
             + ((((x + 16) * 37) ^ ((y + 16) * 101) ^ s_nseed) % (s_namp + 1));
    endfunction

    // Reference three-step search following the requirements.
    task automatic ref_run(input int rng, output int bx, output int by,
                           output int bs, output int zs, output int ne);
        int cx, cy, x, y, s;
        bx = 0; by = 0; bs = sad_of(0, 0); zs = bs; ne = 1;
        r_sx[0] = 0; r_sy[0] = 0;
        for (int step = FS; step >= 1; step = step / 2) begin
            cx = bx; cy = by;
            for (int k = 0; k < 9; k++) begin
                if (k == 4) continue;
                x = cx + step * ((k % 3) - 1);
                y = cy + step * ((k / 3) - 1);
                if (iabs(x) > rng || iabs(y) > rng) continue;
                s = sad_of(x, y);
                if (ne < 32) begin r_sx[ne] = x; r_sy[ne] = y; end
                ne++;
                if (s < bs) begin bs = s; bx = x; by = y; end
            end
        end
    endtask

    // Responder and monitor for the default-limit instance.
    initial begin
        int x, y;
        forever begin
            @(negedge clk);
            if (a_done) begin a_fin = 1; a_dcnt++; end
            if (a_cv) begin
                x = int'(a_dx); y = int'(a_dy);
                if (a_ev < 32) begin a_sx[a_ev] = x; a_sy[a_ev] = y; end
                a_ev++;
                repeat ($urandom_range(0, 2)) begin
                    @(negedge clk);
                    if (a_cv) a_viol++;
                end
                @(negedge clk);
                if (a_cv) a_viol++;
                a_sv = 1'b1; a_sd = SAD_W'(sad_of(x, y));
                @(negedge clk);
                a_sv = 1'b0;
            end
        end
    end

    // Responder and monitor for the narrow-limit instance.
    initial begin
        int x, y;
        forever begin
            @(negedge clk);
            if (b_done) begin b_fin = 1; b_dcnt++; end
            if (b_cv) begin
                x = int'(b_dx); y = int'(b_dy);
                if (iabs(x) > NARROW || iabs(y) > NARROW) b_oor++;
                b_ev++;
                repeat ($urandom_range(0, 2)) begin
                    @(negedge clk);
                    if (b_cv) b_viol++;
                end
                @(negedge clk);
                if (b_cv) b_viol++;
                b_sv = 1'b1; b_sd = SAD_W'(sad_of(x, y));
                @(negedge clk);
                b_sv = 1'b0;
            end
        end
    end

    task automatic run_case(input bit busy_start);
        int bx, by, bs, zs, ne;
        a_ev = 0; b_ev = 0; a_dcnt = 0; b_dcnt = 0;
        a_viol = 0; b_viol = 0; b_oor = 0; a_fin = 0; b_fin = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (busy_start) begin
            repeat ($urandom_range(3, 20)) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        while (!(a_fin && b_fin)) @(negedge clk);
        repeat (3) @(negedge clk);

        ref_run(WIDE, bx, by, bs, zs, ne);
        chk(busy_start ? "R10 wide dx after busy start" : "R3 wide best dx", int'(a_bdx), bx);
        chk("R3 wide best dy", int'(a_bdy), by);
        chk("R7 wide best sad", int'(a_bs), bs);
        chk("R1 wide zero sad", int'(a_zs), zs);
        chk(busy_start ? "R10 wide eval count" : "R6 wide eval count", a_ev, ne);
        chk("R6 wide cap", int'(a_ev <= 25), 1);
        for (int i = 0; i < ne && i < 32; i++) begin
            chk(i == 0 ? "R1 first candidate x" : (i < 9 ? "R2 order x" : "R4 order x"), a_sx[i], r_sx[i]);
            chk(i == 0 ? "R1 first candidate y" : (i < 9 ? "R2 order y" : "R4 order y"), a_sy[i], r_sy[i]);
        end
        chk("R8 wide done pulses", a_dcnt, 1);
        chk("R9 wide no early candidate", a_viol, 0);

        ref_run(NARROW, bx, by, bs, zs, ne);
        chk("R5 narrow best dx", int'(b_bdx), bx);
        chk("R5 narrow best dy", int'(b_bdy), by);
        chk("R5 narrow best sad", int'(b_bs), bs);
        chk("R1 narrow zero sad", int'(b_zs), zs);
        chk("R5 narrow eval count", b_ev, ne);
        chk("R5 narrow nothing out of range", b_oor, 0);
        chk("R8 narrow done pulses", b_dcnt, 1);
        chk("R9 narrow no early candidate", b_viol, 0);
    endtask

    task automatic set_surface(input int tx, input int ty, input int wa, input int wb,
                               input int base, input int namp, input int nseed);
        s_tx = tx; s_ty = ty; s_wa = wa; s_wb = wb;
        s_base = base; s_namp = namp; s_nseed = nseed;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        set_surface(0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R11: reset state at the ports.
        chk("R11 done low", int'(a_done), 0);
        chk("R11 cand_valid low", int'(a_cv), 0);
        chk("R11 best dx zero", int'(a_bdx), 0);
        chk("R11 best sad zero", int'(a_bs), 0);
        chk("R11 zero sad zero", int'(a_zs), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 idle without start", int'(a_cv || b_cv), 0);

        // Directed: flat surface, every tie keeps the origin (R7).
        set_surface(0, 0, 0, 0, 500, 0, 0);
        run_case(0);
        chk("R7 flat keeps origin", int'(a_bdx) * 100 + int'(a_bdy), 0);
        chk("R6 flat uses full budget", a_ev, 25);
        // Directed: far corners and an off-axis target.
        set_surface(7, 7, 3, 3, 100, 0, 0);   run_case(0);
        chk("R4 reaches corner", int'(a_bdx) * 100 + int'(a_bdy), 707);
        set_surface(-7, -7, 2, 2, 40, 0, 0);  run_case(0);
        set_surface(5, -3, 1, 2, 10, 3, 77);  run_case(1);
        set_surface(-2, 6, 0, 4, 0, 0, 0);    run_case(0);

        // Constrained random surfaces, some with a start pulse mid-search.
        for (int n = 0; n < 160; n++) begin
            set_surface(int'($urandom_range(0, 14)) - 7, int'($urandom_range(0, 14)) - 7,
                        int'($urandom_range(0, 8)), int'($urandom_range(0, 8)),
                        int'($urandom_range(0, 2000)), int'($urandom_range(0, 15)),
                        int'($urandom_range(0, 1023)));
            run_case(($urandom_range(0, 3) == 0) ? 1'b1 : 1'b0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule